// File: doc/BRIEF.md
# I2C Status Flag Detection Unit

This block produces and holds three status flags for a two-wire serial controller: a no-acknowledge flag, a stop-condition flag, and one flag that serves both as an arbitration-lost flag and as an overrun flag. It samples the SCL and SDA pin levels through a synchronizer and finds start conditions, stop conditions and SCL rising edges. It combines these with level and strobe inputs from the controller core. Those inputs are master or slave operation, transmit direction, clocked synchronous format, acknowledge checking enable, receive buffer full, address match, byte completion and final-bit received. The core also supplies the SDA value it is driving.

Software reads the flags as one byte and clears a flag by writing 0 to its bit. The write clears the flag only if that flag read as 1 on the most recent read. A flag raised after the read is therefore never lost to a clearing write. When a hardware set and a clearing write arrive in the same cycle, the set wins.

Top module: `i2c_flag_unit`

## Requirements
- R1: After reset `rd_data` is 0x00. The flags sit at bit 4 (no-acknowledge), bit 3 (stop) and bit 2 (arbitration-lost/overrun). Every other bit always reads 0.
- R2: On a synchronized SCL rising edge, bit 4 sets if all of the following hold: `ack_phase` and `is_transmit` are high, the SDA pin is high, and `ack_enable` is 1. With `ack_enable` at 0 the same bus activity leaves bit 4 at 0.
- R3: In master mode, a stop condition (SDA rising while SCL is high) sets bit 3 only if a `byte_done` pulse occurred since the last start condition.
- R4: In slave mode, a stop condition sets bit 3 only if an `addr_match` pulse occurred since the last start condition.
- R5: In master transmit mode without synchronous format, bit 2 sets when `sda_drive` differs from the synchronized SDA pin at an SCL rising edge.
- R6: In master mode, bit 2 sets when a start condition (SDA falling while SCL is high) is detected while `sda_drive` is 1.
- R7: In synchronous format, bit 2 sets when `last_bit_rx` pulses while `rx_full` is 1. It stays clear when `rx_full` is 0.
- R8: Writing 0 to a flag bit clears that flag only if the flag read as 1 on the last read. A write of 0 with no such read leaves the flag set. Writing 1 never clears a flag.
- R9: Each write uses up the read permission. A flag that read as 0 and was set afterwards survives the next write of 0.
- R10: A hardware set event in the same cycle as a qualifying clearing write leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_pin | input | 1 | SCL pin level (asynchronous) |
| sda_pin | input | 1 | SDA pin level (asynchronous) |
| sda_drive | input | 1 | SDA value the controller drives (1 = released/high) |
| is_master | input | 1 | 1 = master operation, 0 = slave |
| is_transmit | input | 1 | 1 = transmitting |
| sync_format | input | 1 | 1 = clocked synchronous format |
| ack_enable | input | 1 | Enables no-acknowledge detection |
| ack_phase | input | 1 | Current SCL pulse is the acknowledge bit |
| rx_full | input | 1 | Receive data register is full |
| addr_match | input | 1 | Pulse: first byte after start matched own or general call address |
| byte_done | input | 1 | Pulse: a frame byte completed |
| last_bit_rx | input | 1 | Pulse: final bit of a byte received |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Status register read value |

## Verification
The main function is tried with bus sequences in both master and slave mode. The same activity is repeated with exactly one qualifier flipped: acknowledge enable on and off, stop with and without a completed byte or address match, start with SDA driven high and low, and final-bit receipt with the receive buffer full and empty. This separates each set condition from its gating. The clearing protocol is tried in four ways: write 0 after reading 1, write 0 without a read, write 1 after a read, and write 0 after reading 0 and then setting the flag. A write that coincides with a set event is also tried. Together these tell the read-arm behaviour apart from a plain write-to-clear and show that a set has priority.

// File: rtl/i2c_flag_pkg.sv
// Package: shared constants for the status flag unit.
// Assumes flags occupy contiguous register bits starting at FLAG_BASE.
package i2c_flag_pkg;
    localparam int NUM_FLAGS = 3;
    localparam int FLAG_BASE = 2;

    // Flag index; register bit = FLAG_BASE + index.
    typedef enum int {
        FLG_ALOV = 0,   // arbitration lost / overrun, bit 2
        FLG_STOP = 1,   // stop detected, bit 3
        FLG_NACK = 2    // no acknowledge, bit 4
    } flag_idx_e;
endpackage

// File: rtl/bus_line_monitor.sv
// Module: bus_line_monitor
// Synchronizes SCL/SDA and reports start, stop and SCL rising edges as
// one-cycle pulses. Assumes an idle (high) bus at reset.
module bus_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;

    // Shift pins through the synchronizer chain, then keep one previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_pin};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_pin};
            scl_prev  <= scl_chain[SYNC_STAGES-1];
            sda_prev  <= sda_chain[SYNC_STAGES-1];
        end
    end

    // Decode edges from synchronized and previous samples.
    always_comb begin
        scl_s     = scl_chain[SYNC_STAGES-1];
        sda_s     = sda_chain[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

    // Start and stop detections must follow an actual SDA transition.
    assert_start_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_prev);
    assert_stop_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> sda_prev);
endmodule

// File: rtl/flag_event_gen.sv
// Module: flag_event_gen
// Turns bus detections and core signals into one set pulse per flag.
// Assumes addr_match and byte_done are single-cycle strobes from the core.
module flag_event_gen
    import i2c_flag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 sda_drive,
    input  logic                 is_master,
    input  logic                 is_transmit,
    input  logic                 sync_format,
    input  logic                 ack_enable,
    input  logic                 ack_phase,
    input  logic                 rx_full,
    input  logic                 addr_match,
    input  logic                 byte_done,
    input  logic                 last_bit_rx,
    output logic [NUM_FLAGS-1:0] set_evt
);
    logic addr_ok;   // address matched since last start
    logic xfer_ok;   // byte completed since last start

    // Track frame qualifiers between start and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_ok <= 1'b0;
            xfer_ok <= 1'b0;
        end else if (start_det || stop_det) begin
            addr_ok <= 1'b0;
            xfer_ok <= 1'b0;
        end else begin
            if (addr_match) addr_ok <= 1'b1;
            if (byte_done)  xfer_ok <= 1'b1;
        end
    end

    logic al_mismatch;
    logic al_start;
    logic overrun;

    // Form set conditions for each flag.
    always_comb begin
        al_mismatch = is_master & is_transmit & ~sync_format & scl_rise & (sda_drive != sda_s);
        al_start    = is_master & start_det & sda_drive;
        overrun     = sync_format & last_bit_rx & rx_full;
        set_evt[FLG_ALOV] = al_mismatch | al_start | overrun;
        set_evt[FLG_STOP] = stop_det & (is_master ? xfer_ok : addr_ok);
        set_evt[FLG_NACK] = scl_rise & ack_phase & is_transmit & ack_enable & sda_s;
    end
endmodule

// File: rtl/status_flag_cell.sv
// Module: status_flag_cell
// One sticky flag with read-then-write-0 clearing. Assumes rd/wr are
// single-cycle strobes; a set in the same cycle as a clear wins.
module status_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    logic arm;
    logic clr;

    // A clear needs a write of 0 following a read that returned 1.
    always_comb clr = wr_i & arm & ~wr_bit_i;

    // Update flag and read arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            arm    <= 1'b0;
        end else begin
            flag_o <= set_i | (flag_o & ~clr);
            if (rd_i)      arm <= flag_o;
            else if (wr_i) arm <= 1'b0;
        end
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_hold_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !arm) |=> flag_o);
    assert_arm_spent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i) |=> !arm);
    assert_clear_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> ($past(wr_i) && !$past(wr_bit_i)));
endmodule

// File: rtl/i2c_flag_unit.sv
// Module: i2c_flag_unit
// Top of the status flag unit: bus monitor, event generation, and one
// flag cell per flag, read back as a byte. Assumes DATA_W covers the flags.
module i2c_flag_unit
    import i2c_flag_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_pin,
    input  logic              sda_pin,
    input  logic              sda_drive,
    input  logic              is_master,
    input  logic              is_transmit,
    input  logic              sync_format,
    input  logic              ack_enable,
    input  logic              ack_phase,
    input  logic              rx_full,
    input  logic              addr_match,
    input  logic              byte_done,
    input  logic              last_bit_rx,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic                 scl_s, sda_s, scl_rise, start_det, stop_det;
    logic [NUM_FLAGS-1:0] set_evt;
    logic [NUM_FLAGS-1:0] flags;
    logic                 unused_wr_bits;

    always_comb unused_wr_bits = ^wr_data ^ scl_s;

    bus_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_pin   (scl_pin),
        .sda_pin   (sda_pin),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    flag_event_gen u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .sda_drive   (sda_drive),
        .is_master   (is_master),
        .is_transmit (is_transmit),
        .sync_format (sync_format),
        .ack_enable  (ack_enable),
        .ack_phase   (ack_phase),
        .rx_full     (rx_full),
        .addr_match  (addr_match),
        .byte_done   (byte_done),
        .last_bit_rx (last_bit_rx),
        .set_evt     (set_evt)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        status_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_evt[g]),
            .rd_i     (reg_rd),
            .wr_i     (reg_wr),
            .wr_bit_i (wr_data[FLAG_BASE+g]),
            .flag_o   (flags[g])
        );
    end

    // Place flags at their register bits; all others read 0.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FLAGS; i++) rd_data[FLAG_BASE+i] = flags[i];
    end

    assert_nack_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_NACK]) |-> $past(ack_enable));
    assert_spare_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~(((DATA_W)'(1) << NUM_FLAGS) - 1) << FLAG_BASE) == '0 ||
        (rd_data & ~((((DATA_W)'(1) << NUM_FLAGS) - 1) << FLAG_BASE)) == '0);
endmodule

// File: tb/i2c_flag_unit_tb.sv
// Scoreboard bench: read tasks queue the expected register value, a monitor
// compares it against rd_data during the read cycle.
module i2c_flag_unit_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       scl_pin = 1, sda_pin = 1, sda_drive = 1;
    logic       is_master = 0, is_transmit = 0, sync_format = 0;
    logic       ack_enable = 0, ack_phase = 0, rx_full = 0;
    logic       addr_match = 0, byte_done = 0, last_bit_rx = 0;
    logic       reg_rd = 0, reg_wr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    i2c_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_pin), .sda_pin(sda_pin),
        .sda_drive(sda_drive), .is_master(is_master), .is_transmit(is_transmit),
        .sync_format(sync_format), .ack_enable(ack_enable), .ack_phase(ack_phase),
        .rx_full(rx_full), .addr_match(addr_match), .byte_done(byte_done),
        .last_bit_rx(last_bit_rx), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    // Monitor: compare rd_data mid-cycle while a read strobe is up.
    always @(negedge clk) begin
        #1;
        if (reg_rd && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            tests++;
            if (rd_data !== e.val) begin
                fails++;
                $display("FAIL %s: rd_data=%02h expected=%02h", e.req, rd_data, e.val);
            end
        end
    end

    task automatic do_read(input logic [7:0] v, input string req);
        exp_t e;
        @(negedge clk);
        e.val = v; e.req = req;
        exp_q.push_back(e);
        reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; wr_data = d;
        @(negedge clk);
        reg_wr = 0; wr_data = 0;
    endtask

    task automatic bus(input logic scl, input logic sda, input logic drv);
        @(negedge clk);
        scl_pin = scl; sda_pin = sda; sda_drive = drv;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1;
        @(negedge clk);
        s = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_cond();
        bus(1, 1, 1);
        bus(1, 0, 0);
    endtask

    task automatic stop_cond();
        bus(0, 0, 0);
        bus(1, 0, 0);
        bus(1, 1, 1);
    endtask

    task automatic clear_flags(input logic [7:0] v, input string req);
        do_read(v, req);
        do_write(8'h00);
        do_read(8'h00, req);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        do_read(8'h00, "R1");

        // R2: no acknowledge during transmit ack slot
        is_master = 1; is_transmit = 1; ack_enable = 1; ack_phase = 1;
        bus(0, 1, 1); bus(1, 1, 1);
        ack_phase = 0; is_transmit = 0;
        clear_flags(8'h10, "R2");
        is_transmit = 1; ack_enable = 0; ack_phase = 1;
        bus(0, 1, 1); bus(1, 1, 1);
        ack_phase = 0; is_transmit = 0;
        do_read(8'h00, "R2");

        // R3: master stop with and without a completed byte
        start_cond(); pulse(byte_done); stop_cond();
        clear_flags(8'h08, "R3");
        start_cond(); stop_cond();
        do_read(8'h00, "R3");

        // R4: slave stop with and without address match
        is_master = 0;
        start_cond(); pulse(addr_match); stop_cond();
        clear_flags(8'h08, "R4");
        start_cond(); stop_cond();
        do_read(8'h00, "R4");

        // R5: master transmit SDA mismatch at SCL rise
        is_master = 1; is_transmit = 1;
        bus(0, 0, 1); bus(1, 0, 1);
        bus(0, 1, 1); bus(1, 1, 1);
        is_transmit = 0;
        clear_flags(8'h04, "R5");

        // R6: start seen while master drives SDA high
        bus(1, 1, 1); bus(1, 0, 1);
        bus(0, 0, 0); bus(1, 0, 0); bus(1, 1, 1);
        clear_flags(8'h04, "R6");

        // R7: overrun with receive buffer full / empty
        is_master = 0; sync_format = 1; rx_full = 1;
        pulse(last_bit_rx);
        clear_flags(8'h04, "R7");
        rx_full = 0;
        pulse(last_bit_rx);
        do_read(8'h00, "R7");

        // R8: write 0 without read, write 1 after read, then proper clear
        rx_full = 1;
        pulse(last_bit_rx);
        do_write(8'h00);
        do_read(8'h04, "R8");
        do_write(8'hFF);
        do_read(8'h04, "R8");
        do_write(8'h00);
        do_read(8'h00, "R8");

        // R9: read 0, then set, then write 0 -> flag survives
        do_read(8'h00, "R9");
        pulse(last_bit_rx);
        do_write(8'h00);
        do_read(8'h04, "R9");
        do_write(8'h00);
        do_read(8'h00, "R9");

        // R10: set event coincides with a qualifying clear
        pulse(last_bit_rx);
        do_read(8'h04, "R10");
        @(negedge clk);
        reg_wr = 1; wr_data = 8'h00; last_bit_rx = 1;
        @(negedge clk);
        reg_wr = 0; last_bit_rx = 0;
        do_read(8'h04, "R10");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule